// File: doc/BRIEF.md
# Dual-clock FIFO with programmable flags

This block is a first-in-first-out buffer whose write side and read side run on unrelated clocks at any frequency ratio. Neither clock has to be the faster one. Words are 18 bits by default and the number of entries is a power-of-two parameter. Deep builds such as 8192 or 16384 entries are set through that parameter, while the default stays small. Writes are accepted on the write clock and reads on the read clock, and both sides may be active in the same moment. The pointers move between the two clock domains as Gray-coded values through a chain of synchronizer flops.

The write side reports full, half-full and almost-full. The read side reports empty and almost-empty. The almost-empty and almost-full thresholds are held in offset registers. A master reset loads them from one of two preset pairs, chosen by a select pin. They can also be loaded later, either one bit per write clock on a serial input or as whole words taken from the write data bus.

A mode pin, sampled during master reset, selects one of two read timings:
- **Standard timing:** a read request produces the word one read clock later.
- **Fall-through timing:** the head word is presented without any request.

In fall-through timing, the two status outputs change meaning and become output-ready and input-ready. A partial reset empties the buffer but keeps the mode and the offsets. A rewind pulse replays the stored data from the first location.

Top module: `dc_fifo_pflag`

## Requirements
- R1: After master reset in standard mode, rd_flag (empty) is 1, wr_flag (full) is 0, half_full is 0, almost_empty is 1, almost_full is 0 and rd_data is 0.
- R2: In standard mode, a read with rd_flag low puts the oldest stored word on rd_data at the next read-clock edge. Words leave in write order, including when writes and reads run at the same time on different clocks.
- R3: With N entries stored (N = DEPTH), wr_flag in standard mode is 1. A further write is dropped: after draining the N words, the buffer reports empty.
- R4: A read while empty is ignored: rd_data keeps its value, and a later read returns the first word written afterwards.
- R5: half_full is 1 exactly when more than DEPTH/2 words are stored.
- R6: almost_empty is 1 exactly when the stored count (in the storage array) is at most the almost-empty offset.
- R7: almost_full is 1 exactly when the stored count is at least DEPTH minus the almost-full offset.
- R8: Master reset with ofs_pick=0 loads the offsets AE_PRE0/AF_PRE0; with ofs_pick=1 it loads AE_PRE1/AF_PRE1.
- R9: While ofs_load is 1, each write-enabled cycle stores the low OFF_W bits of wr_data into an offset register instead of the buffer. The first such cycle after master reset fills the almost-empty offset, the next fills the almost-full offset, and the two alternate from there.
- R10: While ser_en is 1 and ofs_load is 0, each write clock shifts ser_din into the LSB of the concatenation {almost-empty offset, almost-full offset}. After 2*OFF_W bits, the first bit sent is the almost-empty MSB.
- R11: Partial reset empties the buffer but keeps both offsets and the timing mode.
- R12: With mode_fwft=1 during master reset, the first word written appears on rd_data with rd_flag (output-ready) 1 and no read request. Each read advances to the next word. wr_flag becomes input-ready, which is 0 only when the storage array is full.
- R13: A rewind pulse on the read clock returns the read pointer to the first location. Subsequent reads replay the words from the first one written; in fall-through mode the first word reappears one read clock after the rewind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low |
| prs_n | input | 1 | Partial reset, active low |
| mode_fwft | input | 1 | Timing mode, sampled during master reset (1 = fall-through) |
| ofs_pick | input | 1 | Preset offset pair select, sampled during master reset |
| wr_en | input | 1 | Write enable (write clock) |
| ofs_load | input | 1 | Route enabled writes to the offset registers |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset bit |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable (read clock) |
| rewind | input | 1 | Retransmit from first location (read clock) |
| rd_data | output | DATA_W | Read data register |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | More than half the depth stored |
| almost_empty | output | 1 | Stored count at or below the almost-empty offset |
| almost_full | output | 1 | Stored count at or above DEPTH minus the almost-full offset |

## Verification
The bench walks the occupancy across each flag threshold one word at a time. A design with an off-by-one compare would show a flag one word early or late. It writes into a full buffer and reads from an empty one; a design that let either through would return a stray word or lose the head word on drain. It loads offsets through both ports and then issues a partial reset: a wrong shift direction, a swapped register order, or a partial reset that also cleared the offsets would move the almost-flag thresholds away from the loaded values. Rewind and fall-through timing are checked against the exact word order. A rewind that missed the first location, or a fall-through path that waited for a request, would show the wrong word or a low output-ready.

// File: rtl/dc_fifo_pflag_pkg.sv
package dc_fifo_pflag_pkg;
   typedef enum logic {MODE_STD  = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;
   typedef enum logic {SEL_AE    = 1'b0, SEL_AF    = 1'b1} ofs_sel_e;
endpackage

// File: rtl/dc_fifo_pflag_sync.sv
module dc_fifo_pflag_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[s] <= '0;
         else if (s == 0) stage[s] <= din;
         else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = stage[STAGES-1];
endmodule

// File: rtl/dc_fifo_pflag_wr.sv
module dc_fifo_pflag_wr
   import dc_fifo_pflag_pkg::*;
#(
   parameter int AW      = 8,
   parameter int OFF_W   = 8,
   parameter int AE_PRE0 = 7,
   parameter int AE_PRE1 = 31,
   parameter int AF_PRE0 = 7,
   parameter int AF_PRE1 = 31
) (
   input  logic             wclk,
   input  logic             rst_n,
   input  logic             mrs_n,
   input  logic             mode_in,
   input  logic             pick_in,
   input  logic             wr_en,
   input  logic             ofs_load,
   input  logic             ser_en,
   input  logic             ser_din,
   input  logic [OFF_W-1:0] ofs_word,
   input  logic [AW:0]      rgray_s,
   output logic [AW:0]      wbin,
   output logic [AW:0]      wgray,
   output logic             mem_we,
   output logic             full,
   output logic             wr_flag,
   output logic             half_full,
   output logic             almost_full,
   output logic [OFF_W-1:0] ae_off,
   output logic [OFF_W-1:0] af_off
);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(2**AW);
   localparam logic [AW:0] HALF_CNT = (AW+1)'(2**(AW-1));

   fifo_mode_e  mode_w;
   ofs_sel_e    ld_sel;
   logic [AW:0] rbin_s;
   logic [AW:0] wcnt;
   logic [AW:0] wbin_nxt;

   always_comb begin
      rbin_s[AW] = rgray_s[AW];
      for (int i = AW-1; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
   end

   assign wcnt        = wbin - rbin_s;
   assign full        = (wcnt == FULL_CNT);
   assign half_full   = (wcnt > HALF_CNT);
   assign almost_full = (wcnt >= (FULL_CNT - {1'b0, af_off}));
   assign wr_flag     = (mode_w == MODE_FWFT) ? ~full : full;
   assign mem_we      = wr_en & ~ofs_load & ~full;
   assign wbin_nxt    = wbin + {{AW{1'b0}}, mem_we};

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nxt;
         wgray <= (wbin_nxt >> 1) ^ wbin_nxt;
      end
   end

   always_ff @(posedge wclk) begin
      if (!mrs_n) begin
         mode_w <= mode_in ? MODE_FWFT : MODE_STD;
         ld_sel <= SEL_AE;
         ae_off <= pick_in ? OFF_W'(AE_PRE1) : OFF_W'(AE_PRE0);
         af_off <= pick_in ? OFF_W'(AF_PRE1) : OFF_W'(AF_PRE0);
      end else if (ofs_load && wr_en) begin
         if (ld_sel == SEL_AE) begin
            ae_off <= ofs_word;
            ld_sel <= SEL_AF;
         end else begin
            af_off <= ofs_word;
            ld_sel <= SEL_AE;
         end
      end else if (ser_en && !ofs_load) begin
         {ae_off, af_off} <= {ae_off[OFF_W-2:0], af_off, ser_din};
      end
   end
endmodule

// File: rtl/dc_fifo_pflag_rd.sv
module dc_fifo_pflag_rd
   import dc_fifo_pflag_pkg::*;
#(
   parameter int DW    = 18,
   parameter int AW    = 8,
   parameter int OFF_W = 8
) (
   input  logic             rclk,
   input  logic             rst_n,
   input  logic             mrs_n,
   input  logic             mode_in,
   input  logic             rd_en,
   input  logic             rewind,
   input  logic [DW-1:0]    mem_q,
   input  logic [AW:0]      wgray_s,
   input  logic [OFF_W-1:0] ae_off,
   output logic [AW:0]      rbin,
   output logic [AW:0]      rgray,
   output logic [DW-1:0]    rd_data,
   output logic             rd_flag,
   output logic             empty,
   output logic             almost_empty
);
   fifo_mode_e  mode_r;
   logic        valid;
   logic        pop;
   logic [AW:0] wbin_s;
   logic [AW:0] rcnt;
   logic [AW:0] rbin_nxt;

   always_comb begin
      wbin_s[AW] = wgray_s[AW];
      for (int i = AW-1; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign empty        = (rbin == wbin_s);
   assign rcnt         = wbin_s - rbin;
   assign almost_empty = (rcnt <= {1'b0, ae_off});
   assign pop          = ~empty & ((mode_r == MODE_FWFT) ? (~valid | rd_en) : rd_en);
   assign rd_flag      = (mode_r == MODE_FWFT) ? valid : empty;
   assign rbin_nxt     = rbin + {{AW{1'b0}}, 1'b1};

   always_ff @(posedge rclk) begin
      if (!mrs_n) mode_r <= mode_in ? MODE_FWFT : MODE_STD;
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         rd_data <= '0;
         valid   <= 1'b0;
      end else if (rewind) begin
         rbin    <= '0;
         rgray   <= '0;
         valid   <= 1'b0;
      end else if (pop) begin
         rbin    <= rbin_nxt;
         rgray   <= (rbin_nxt >> 1) ^ rbin_nxt;
         rd_data <= mem_q;
         valid   <= 1'b1;
      end else if (rd_en) begin
         valid   <= 1'b0;
      end
   end
endmodule

// File: rtl/dc_fifo_pflag.sv
module dc_fifo_pflag #(
   parameter int DATA_W      = 18,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter int AE_PRE0     = 7,
   parameter int AE_PRE1     = 31,
   parameter int AF_PRE0     = 7,
   parameter int AF_PRE1     = 31
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrs_n,
   input  logic              prs_n,
   input  logic              mode_fwft,
   input  logic              ofs_pick,
   input  logic              wr_en,
   input  logic              ofs_load,
   input  logic              ser_en,
   input  logic              ser_din,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              rewind,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_flag,
   output logic              wr_flag,
   output logic              half_full,
   output logic              almost_empty,
   output logic              almost_full
);
   localparam int AW    = $clog2(DEPTH);
   localparam int OFF_W = AW;

   initial begin : elab_checks
      assert (DEPTH >= 4 && (DEPTH & (DEPTH-1)) == 0)
         else $error("DEPTH must be a power of two of at least 4");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (DATA_W >= OFF_W) else $error("DATA_W must cover the offset width");
      assert (AE_PRE0 < DEPTH && AE_PRE1 < DEPTH && AF_PRE0 < DEPTH && AF_PRE1 < DEPTH)
         else $error("preset offsets must be below DEPTH");
   end

   logic              rst_n;
   logic [AW:0]       wbin, wgray, wgray_s;
   logic [AW:0]       rbin, rgray, rgray_s;
   logic              mem_we, full, empty;
   logic [OFF_W-1:0]  ae_off, af_off;
   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] mem_q;

   assign rst_n = mrs_n & prs_n;

   always_ff @(posedge wclk) begin
      if (mem_we) mem[wbin[AW-1:0]] <= wr_data;
   end
   assign mem_q = mem[rbin[AW-1:0]];

   dc_fifo_pflag_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rclk), .rst_n(rst_n), .din(wgray), .dout(wgray_s));

   dc_fifo_pflag_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wclk), .rst_n(rst_n), .din(rgray), .dout(rgray_s));

   dc_fifo_pflag_wr #(
      .AW(AW), .OFF_W(OFF_W),
      .AE_PRE0(AE_PRE0), .AE_PRE1(AE_PRE1), .AF_PRE0(AF_PRE0), .AF_PRE1(AF_PRE1)
   ) u_wr (
      .wclk(wclk), .rst_n(rst_n), .mrs_n(mrs_n), .mode_in(mode_fwft),
      .pick_in(ofs_pick), .wr_en(wr_en), .ofs_load(ofs_load), .ser_en(ser_en),
      .ser_din(ser_din), .ofs_word(wr_data[OFF_W-1:0]), .rgray_s(rgray_s),
      .wbin(wbin), .wgray(wgray), .mem_we(mem_we), .full(full),
      .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full),
      .ae_off(ae_off), .af_off(af_off));

   dc_fifo_pflag_rd #(.DW(DATA_W), .AW(AW), .OFF_W(OFF_W)) u_rd (
      .rclk(rclk), .rst_n(rst_n), .mrs_n(mrs_n), .mode_in(mode_fwft),
      .rd_en(rd_en), .rewind(rewind), .mem_q(mem_q), .wgray_s(wgray_s),
      .ae_off(ae_off), .rbin(rbin), .rgray(rgray), .rd_data(rd_data),
      .rd_flag(rd_flag), .empty(empty), .almost_empty(almost_empty));
endmodule

// File: rtl/dc_fifo_pflag_chk.sv
module dc_fifo_pflag_chk #(
   parameter int AW = 8
) (
   input logic        wclk,
   input logic        rclk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        ofs_load,
   input logic        rd_en,
   input logic        rewind,
   input logic        full,
   input logic        empty,
   input logic        half_full,
   input logic        almost_full,
   input logic        almost_empty,
   input logic [AW:0] wbin,
   input logic [AW:0] rbin,
   input logic [AW:0] wgray
);
   // R2: the write pointer code crossing domains changes by at most one bit
   p_gray_step_r2: assert property (@(posedge wclk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   // R3: a write into a full buffer leaves the write pointer alone
   p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
      (full && wr_en && !ofs_load) |=> $stable(wbin));

   // R4: a read from an empty buffer leaves the read pointer alone
   p_no_underrun_r4: assert property (@(posedge rclk) disable iff (!rst_n)
      (empty && rd_en && !rewind) |=> $stable(rbin));

   // R5: a full buffer is always past half
   p_full_half_r5: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> half_full);

   // R6: an empty buffer is always almost empty
   p_empty_ae_r6: assert property (@(posedge rclk) disable iff (!rst_n)
      empty |-> almost_empty);

   // R7: a full buffer is always almost full
   p_full_af_r7: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> almost_full);

   // R13: rewind returns the read pointer to the first location
   p_rewind_r13: assert property (@(posedge rclk) disable iff (!rst_n)
      rewind |=> (rbin == '0));
endmodule

bind dc_fifo_pflag dc_fifo_pflag_chk #(.AW(AW)) u_chk (
   .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .ofs_load(ofs_load),
   .rd_en(rd_en), .rewind(rewind), .full(full), .empty(empty),
   .half_full(half_full), .almost_full(almost_full), .almost_empty(almost_empty),
   .wbin(wbin), .rbin(rbin), .wgray(wgray));

// File: tb/tb_dc_fifo_pflag.sv
module tb_dc_fifo_pflag;
   localparam int CLK_PERIOD  = 10;
   localparam int RCLK_PERIOD = 14;
   localparam int DW    = 18;
   localparam int DEPTH = 32;

   logic wclk = 1'b0, rclk = 1'b0;
   logic mrs_n = 1'b0, prs_n = 1'b1, mode_fwft = 1'b0, ofs_pick = 1'b0;
   logic wr_en = 1'b0, ofs_load = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic rd_en = 1'b0, rewind = 1'b0;
   logic [DW-1:0] rd_data;
   logic rd_flag, wr_flag, half_full, almost_empty, almost_full;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) wclk = ~wclk;
   always #(RCLK_PERIOD/2) rclk = ~rclk;

   dc_fifo_pflag #(
      .DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2),
      .AE_PRE0(2), .AE_PRE1(6), .AF_PRE0(3), .AF_PRE1(5)
   ) dut (
      .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .prs_n(prs_n),
      .mode_fwft(mode_fwft), .ofs_pick(ofs_pick), .wr_en(wr_en),
      .ofs_load(ofs_load), .ser_en(ser_en), .ser_din(ser_din),
      .wr_data(wr_data), .rd_en(rd_en), .rewind(rewind), .rd_data(rd_data),
      .rd_flag(rd_flag), .wr_flag(wr_flag), .half_full(half_full),
      .almost_empty(almost_empty), .almost_full(almost_full));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge rclk);
      repeat (6) @(negedge wclk);
   endtask

   task automatic do_mrs(input logic fw, input logic pick);
      @(negedge wclk);
      mrs_n = 1'b0; mode_fwft = fw; ofs_pick = pick;
      repeat (4) @(negedge rclk);
      repeat (4) @(negedge wclk);
      mrs_n = 1'b1;
      settle();
   endtask

   task automatic do_prs();
      @(negedge wclk);
      prs_n = 1'b0;
      repeat (4) @(negedge rclk);
      @(negedge wclk);
      prs_n = 1'b1;
      settle();
   endtask

   task automatic wr(input logic [DW-1:0] v);
      @(negedge wclk);
      wr_en = 1'b1; wr_data = v;
      @(negedge wclk);
      wr_en = 1'b0;
   endtask

   task automatic rd(output logic [DW-1:0] v);
      @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic pulse_rewind();
      @(negedge rclk);
      rewind = 1'b1;
      @(negedge rclk);
      rewind = 1'b0;
   endtask

   task automatic t_reset();
      do_mrs(1'b0, 1'b0);
      chk("R1 empty",        rd_flag, 1);
      chk("R1 full",         wr_flag, 0);
      chk("R1 half_full",    half_full, 0);
      chk("R1 almost_empty", almost_empty, 1);
      chk("R1 almost_full",  almost_full, 0);
      chk("R1 rd_data",      rd_data, 0);
   endtask

   task automatic t_empty_read();
      logic [DW-1:0] v;
      rd(v);
      chk("R4 data kept on empty read", rd_data, 0);
      wr(18'h0A5A5); wr(18'h01234);
      settle();
      rd(v); chk("R4 first word after empty read", v, 18'h0A5A5);
      rd(v); chk("R2 second word", v, 18'h01234);
      chk("R2 empty after drain", rd_flag, 1);
   endtask

   task automatic t_fill_levels();
      logic [DW-1:0] v;
      for (int c = 1; c <= DEPTH; c++) begin
         wr(DW'(32'h200 + c - 1));
         if (c == 2 || c == 3 || c == 16 || c == 17 || c == 28 || c == 29 || c == 31 || c == 32) begin
            settle();
            chk("R6 almost_empty level", almost_empty, (c <= 2) ? 1 : 0);
            chk("R5 half_full level",    half_full,    (c > 16) ? 1 : 0);
            chk("R7 almost_full level",  almost_full,  (c >= 29) ? 1 : 0);
            chk("R3 full level",         wr_flag,      (c == 32) ? 1 : 0);
         end
      end
      wr(18'h3FFFF);
      settle();
      for (int i = 0; i < DEPTH; i++) begin
         rd(v);
         chk("R3 drain order", v, DW'(32'h200 + i));
      end
      settle();
      chk("R3 write while full dropped", rd_flag, 1);
   endtask

   task automatic fill_to(input int from, input int upto);
      for (int c = from; c <= upto; c++) wr(DW'(c));
   endtask

   task automatic t_preset_alt();
      do_mrs(1'b0, 1'b1);
      fill_to(1, 6);  settle(); chk("R8 alt preset ae at 6", almost_empty, 1);
      fill_to(7, 7);  settle(); chk("R8 alt preset ae at 7", almost_empty, 0);
      fill_to(8, 26); settle(); chk("R8 alt preset af at 26", almost_full, 0);
      fill_to(27, 27); settle(); chk("R8 alt preset af at 27", almost_full, 1);
   endtask

   task automatic t_parallel_and_partial();
      do_mrs(1'b0, 1'b0);
      @(negedge wclk); ofs_load = 1'b1;
      wr(18'd10); wr(18'd12);
      @(negedge wclk); ofs_load = 1'b0;
      settle();
      chk("R9 offset words not stored", rd_flag, 1);
      fill_to(1, 10);  settle(); chk("R9 loaded ae at 10", almost_empty, 1);
      fill_to(11, 11); settle(); chk("R9 loaded ae at 11", almost_empty, 0);
      fill_to(12, 19); settle(); chk("R9 loaded af at 19", almost_full, 0);
      fill_to(20, 20); settle(); chk("R9 loaded af at 20", almost_full, 1);
      do_prs();
      chk("R11 partial reset empties", rd_flag, 1);
      fill_to(1, 10);  settle(); chk("R11 ae kept at 10", almost_empty, 1);
      fill_to(11, 11); settle(); chk("R11 ae kept at 11", almost_empty, 0);
      fill_to(12, 20); settle(); chk("R11 af kept at 20", almost_full, 1);
   endtask

   task automatic t_serial();
      logic [9:0] bits;
      bits = {5'd4, 5'd8};
      do_prs();
      for (int i = 9; i >= 0; i--) begin
         @(negedge wclk);
         ser_en = 1'b1; ser_din = bits[i];
      end
      @(negedge wclk); ser_en = 1'b0;
      settle();
      fill_to(1, 4);   settle(); chk("R10 serial ae at 4", almost_empty, 1);
      fill_to(5, 5);   settle(); chk("R10 serial ae at 5", almost_empty, 0);
      fill_to(6, 23);  settle(); chk("R10 serial af at 23", almost_full, 0);
      fill_to(24, 24); settle(); chk("R10 serial af at 24", almost_full, 1);
   endtask

   task automatic t_rewind_std();
      logic [DW-1:0] v;
      do_prs();
      for (int i = 0; i < 4; i++) wr(DW'(32'h300 + i));
      settle();
      rd(v); rd(v);
      chk("R13 pre-rewind read", v, 18'h301);
      pulse_rewind();
      settle();
      for (int i = 0; i < 4; i++) begin
         rd(v);
         chk("R13 replay order", v, DW'(32'h300 + i));
      end
   endtask

   task automatic t_concurrent();
      do_prs();
      fork
         begin
            for (int i = 0; i < 20; i++) wr(DW'(32'h400 + i));
         end
         begin
            for (int i = 0; i < 20; i++) begin
               logic [DW-1:0] v;
               @(negedge rclk);
               while (rd_flag) @(negedge rclk);
               rd_en = 1'b1;
               @(negedge rclk);
               rd_en = 1'b0;
               v = rd_data;
               chk("R2 concurrent order", v, DW'(32'h400 + i));
            end
         end
      join
   endtask

   task automatic t_fwft();
      do_mrs(1'b1, 1'b0);
      chk("R12 output-ready low when empty", rd_flag, 0);
      chk("R12 input-ready high when empty", wr_flag, 1);
      wr(18'h100); wr(18'h101); wr(18'h102);
      settle();
      chk("R12 first word without request", rd_data, 18'h100);
      chk("R12 output-ready high", rd_flag, 1);
      @(negedge rclk); rd_en = 1'b1; @(negedge rclk); rd_en = 1'b0;
      chk("R12 advance to second", rd_data, 18'h101);
      @(negedge rclk); rd_en = 1'b1; @(negedge rclk); rd_en = 1'b0;
      chk("R12 advance to third", rd_data, 18'h102);
      @(negedge rclk); rd_en = 1'b1; @(negedge rclk); rd_en = 1'b0;
      chk("R12 output-ready low after last", rd_flag, 0);
      pulse_rewind();
      settle();
      chk("R13 fall-through replay data", rd_data, 18'h100);
      chk("R13 fall-through replay ready", rd_flag, 1);
      do_prs();
      for (int i = 0; i < DEPTH; i++) wr(DW'(32'h500 + i));
      settle();
      chk("R12 input-ready with head in output register", wr_flag, 1);
      wr(18'h3AAAA);
      settle();
      chk("R12 input-ready low when array full", wr_flag, 0);
      chk("R11 mode kept over partial reset", rd_data, 18'h500);
   endtask

   initial begin
      t_reset();
      t_empty_read();
      t_fill_levels();
      t_preset_alt();
      t_parallel_and_partial();
      t_serial();
      t_rewind_std();
      t_concurrent();
      t_fwft();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule